// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block chooses what the processor enters when a take strobe arrives. It looks at a pending exception code, and at a hardware interrupt request that an external interrupt controller presents with a vector and a priority level. It then commits the whole entry state update on one clock edge. The new program counter and status word, the saved copies of status, program counter and R15, and the exception or interrupt event register are all held in registers inside the block. The surrounding core reads these registers.

An exception always wins over an interrupt. While the status block bit is set, most exceptions are escalated to a reset-class entry, and interrupts are refused unless the core is asleep. Entry sets the block, privileged-mode and register-bank bits. The saved program counter is rewound by 2 for faults in a delay slot and advanced by 2 for a trap instruction. Control is dispatched to one of four targets: the fixed reset address, or the vector base plus 0x100, 0x400 or 0x600.

Top module: `exc_entry_seq`

## Requirements
- R1: When `take` is high and `exc_pending` is high, the exception is entered and `intevt_out` keeps its value, even if `irq_req` is also high. An interrupt is considered only with no exception pending.
- R2: When `sr_in[28]` (block bit) is 1, an exception whose code is not 0x1E0 is recorded in `expevt_out` as 0x000 and handled as reset-class. Code 0x1E0 is taken unchanged.
- R3: An interrupt is accepted only if `irq_level` is strictly greater than `sr_in[7:4]`, and only if `sr_in[28]` is 0 or `sleep_in` is 1. Otherwise no output register changes and `entered` stays 0.
- R4: On any entry, `ssr_out` takes `sr_in` and `sgr_out` takes `r15_in`. `sr_out` is `sr_in` with bits 28, 29 and 30 set, changed further only as R6 states.
- R5: If `dslot_cond` or `dslot_uncond` is 1 at entry, `spc_out` is `pc_in - 2` and `dslot_clear` pulses for one cycle. Otherwise `spc_out` is `pc_in` (before R8).
- R6: Reset-class codes 0x000, 0x020 and 0x140 set `pc_out` to 0xA0000000, clear `sr_out[15]` and force `sr_out[7:4]` to 0xF.
- R7: Codes 0x040 and 0x060 set `pc_out` to `vbr_in + 0x400`. Any other non-reset-class code sets `pc_out` to `vbr_in + 0x100`.
- R8: For code 0x160, `spc_out` is advanced by 2 on top of R5, so a trap in a delay slot saves `pc_in`.
- R9: An exception writes its effective code to `expevt_out`. An interrupt writes `irq_vector` to `intevt_out`, sets `pc_out` to `vbr_in + 0x600` and leaves `expevt_out` unchanged.
- R10: The outputs change only on a clock edge where `take` is 1 and an entry is accepted. `entered` is 1 for exactly the cycle after each accepted entry. `wake` pulses alongside it when `sleep_in` was 1.
- R11: After reset, every output register and pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take | input | 1 | Strobe qualifying the entry decision |
| exc_pending | input | 1 | An exception is pending |
| exc_code | input | 12 | Pending exception code |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_vector | input | 12 | Interrupt vector code |
| irq_level | input | 4 | Interrupt priority level |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current R15 |
| vbr_in | input | 32 | Vector base |
| dslot_uncond | input | 1 | Current instruction is in an unconditional delay slot |
| dslot_cond | input | 1 | Current instruction is in a conditional delay slot |
| sleep_in | input | 1 | Core is in sleep state |
| pc_out | output | 32 | Program counter after entry |
| sr_out | output | 32 | Status word after entry |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved program counter |
| sgr_out | output | 32 | Saved R15 |
| expevt_out | output | 12 | Last exception code |
| intevt_out | output | 12 | Last interrupt vector |
| entered | output | 1 | One-cycle pulse per accepted entry |
| dslot_clear | output | 1 | Pulse telling the core to clear its delay-slot flags |
| wake | output | 1 | Pulse telling the core to leave sleep |

## Verification
Directed cases pit an exception against a simultaneous interrupt, to separate the arbitration order. They also set the block bit with and without sleep, to separate escalation from refusal. An interrupt level equal to the mask confirms that the comparison is strict. Further cases combine the trap code with a delay slot, to show that the two program-counter adjustments stack. A few hundred random cycles then draw codes from the reset-class, miss, trap, bypass and general groups under random status words, flags and strobes. These cycles expose any wrong vector, status-bit or saved-value path.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    parameter int XLEN   = 32;
    parameter int CODE_W = 12;
    parameter int LVL_W  = 4;

    localparam int BIT_BL   = 28;
    localparam int BIT_RB   = 29;
    localparam int BIT_MD   = 30;
    localparam int BIT_FD   = 15;
    localparam int MASK_LO  = 4;
    localparam int MASK_HI  = MASK_LO + LVL_W - 1;

    localparam logic [CODE_W-1:0] C_POWER   = CODE_W'(12'h000);
    localparam logic [CODE_W-1:0] C_MANUAL  = CODE_W'(12'h020);
    localparam logic [CODE_W-1:0] C_MULTI   = CODE_W'(12'h140);
    localparam logic [CODE_W-1:0] C_MISS_RD = CODE_W'(12'h040);
    localparam logic [CODE_W-1:0] C_MISS_WR = CODE_W'(12'h060);
    localparam logic [CODE_W-1:0] C_TRAP    = CODE_W'(12'h160);
    localparam logic [CODE_W-1:0] C_BYPASS  = CODE_W'(12'h1E0);

    localparam logic [XLEN-1:0] RESET_TARGET = XLEN'(32'hA000_0000);
    localparam logic [XLEN-1:0] OFS_GENERAL  = XLEN'(32'h100);
    localparam logic [XLEN-1:0] OFS_MISS     = XLEN'(32'h400);
    localparam logic [XLEN-1:0] OFS_IRQ      = XLEN'(32'h600);
    localparam logic [XLEN-1:0] PC_STEP      = XLEN'(2);

    typedef enum logic [1:0] {
        ENTER_NONE = 2'd0,
        ENTER_EXC  = 2'd1,
        ENTER_IRQ  = 2'd2
    } enter_kind_e;

    typedef struct packed {
        enter_kind_e        kind;
        logic [CODE_W-1:0]  code;
    } decision_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] spc;
    } entry_t;

    function automatic logic is_reset_class(input logic [CODE_W-1:0] c);
        return (c == C_POWER) || (c == C_MANUAL) || (c == C_MULTI);
    endfunction

    function automatic logic is_miss_class(input logic [CODE_W-1:0] c);
        return (c == C_MISS_RD) || (c == C_MISS_WR);
    endfunction
endpackage

// File: rtl/exc_select.sv
module exc_select
    import exc_entry_pkg::*;
(
    input  logic              take,
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              blocked,
    input  logic [LVL_W-1:0]  imask,
    input  logic              sleep_in,
    output decision_t         dec
);
    logic irq_ok;

    assign irq_ok = irq_req && (!blocked || sleep_in) && (irq_level > imask);

    always_comb begin
        dec.kind = ENTER_NONE;
        dec.code = exc_code;
        if (take) begin
            if (exc_pending) begin
                dec.kind = ENTER_EXC;
                if (blocked && exc_code != C_BYPASS) begin
                    dec.code = C_POWER;
                end
            end else if (irq_ok) begin
                dec.kind = ENTER_IRQ;
            end
        end
    end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
    import exc_entry_pkg::*;
(
    input  decision_t       dec,
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] vbr_in,
    input  logic            in_slot,
    output entry_t          nxt
);
    logic [XLEN-1:0] spc_base;
    logic [XLEN-1:0] sr_base;

    assign spc_base = in_slot ? (pc_in - PC_STEP) : pc_in;

    always_comb begin
        sr_base         = sr_in;
        sr_base[BIT_BL] = 1'b1;
        sr_base[BIT_MD] = 1'b1;
        sr_base[BIT_RB] = 1'b1;
    end

    always_comb begin
        nxt.sr  = sr_base;
        nxt.spc = spc_base;
        nxt.pc  = vbr_in + OFS_GENERAL;
        if (dec.kind == ENTER_IRQ) begin
            nxt.pc = vbr_in + OFS_IRQ;
        end else if (is_reset_class(dec.code)) begin
            nxt.pc                   = RESET_TARGET;
            nxt.sr[BIT_FD]           = 1'b0;
            nxt.sr[MASK_HI:MASK_LO]  = '1;
        end else if (is_miss_class(dec.code)) begin
            nxt.pc = vbr_in + OFS_MISS;
        end else if (dec.code == C_TRAP) begin
            nxt.spc = spc_base + PC_STEP;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_vector,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic              dslot_uncond,
    input  logic              dslot_cond,
    input  logic              sleep_in,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   ssr_out,
    output logic [XLEN-1:0]   spc_out,
    output logic [XLEN-1:0]   sgr_out,
    output logic [CODE_W-1:0] expevt_out,
    output logic [CODE_W-1:0] intevt_out,
    output logic              entered,
    output logic              dslot_clear,
    output logic              wake
);
    decision_t dec;
    entry_t    nxt;
    logic      in_slot;
    logic      accept;

    assign in_slot = dslot_uncond | dslot_cond;
    assign accept  = (dec.kind != ENTER_NONE);

    exc_select u_select (
        .take        (take),
        .exc_pending (exc_pending),
        .exc_code    (exc_code),
        .irq_req     (irq_req),
        .irq_level   (irq_level),
        .blocked     (sr_in[BIT_BL]),
        .imask       (sr_in[MASK_HI:MASK_LO]),
        .sleep_in    (sleep_in),
        .dec         (dec)
    );

    exc_state_calc u_calc (
        .dec     (dec),
        .sr_in   (sr_in),
        .pc_in   (pc_in),
        .vbr_in  (vbr_in),
        .in_slot (in_slot),
        .nxt     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_out      <= '0;
            sr_out      <= '0;
            ssr_out     <= '0;
            spc_out     <= '0;
            sgr_out     <= '0;
            expevt_out  <= '0;
            intevt_out  <= '0;
            entered     <= 1'b0;
            dslot_clear <= 1'b0;
            wake        <= 1'b0;
        end else begin
            entered     <= accept;
            dslot_clear <= accept & in_slot;
            wake        <= accept & sleep_in;
            if (accept) begin
                pc_out  <= nxt.pc;
                sr_out  <= nxt.sr;
                spc_out <= nxt.spc;
                ssr_out <= sr_in;
                sgr_out <= r15_in;
                if (dec.kind == ENTER_EXC) begin
                    expevt_out <= dec.code;
                end else begin
                    intevt_out <= irq_vector;
                end
            end
        end
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_entry_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              take,
    input logic              exc_pending,
    input logic [CODE_W-1:0] exc_code,
    input logic              irq_req,
    input logic [LVL_W-1:0]  irq_level,
    input logic [XLEN-1:0]   sr_in,
    input logic [XLEN-1:0]   pc_out,
    input logic [XLEN-1:0]   sr_out,
    input logic [XLEN-1:0]   ssr_out,
    input logic [CODE_W-1:0] expevt_out,
    input logic [CODE_W-1:0] intevt_out,
    input logic              entered
);
    AST_EXC_WINS: assert property (@(posedge clk) disable iff (rst)
        (take && exc_pending) |=> (entered && $stable(intevt_out))); // R1

    AST_BLOCK_ESCALATE: assert property (@(posedge clk) disable iff (rst)
        (take && exc_pending && sr_in[BIT_BL] && exc_code != C_BYPASS)
        |=> (expevt_out == C_POWER && pc_out == RESET_TARGET)); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (take && !exc_pending && irq_req && irq_level <= sr_in[MASK_HI:MASK_LO])
        |=> !entered); // R3

    AST_SAVE_STATUS: assert property (@(posedge clk) disable iff (rst)
        (take && exc_pending) |=> (ssr_out == $past(sr_in))); // R4

    AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (rst)
        entered |-> (sr_out[BIT_BL] && sr_out[BIT_MD] && sr_out[BIT_RB])); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !take |=> (!entered && $stable(pc_out) && $stable(sr_out))); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .exc_pending (exc_pending),
    .exc_code    (exc_code),
    .irq_req     (irq_req),
    .irq_level   (irq_level),
    .sr_in       (sr_in),
    .pc_out      (pc_out),
    .sr_out      (sr_out),
    .ssr_out     (ssr_out),
    .expevt_out  (expevt_out),
    .intevt_out  (intevt_out),
    .entered     (entered)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        take = 1'b0;
    logic        exc_pending = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic [11:0] irq_vector = '0;
    logic [3:0]  irq_level = '0;
    logic [31:0] sr_in = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] r15_in = '0;
    logic [31:0] vbr_in = '0;
    logic        dslot_uncond = 1'b0;
    logic        dslot_cond = 1'b0;
    logic        sleep_in = 1'b0;

    logic [31:0] pc_out, sr_out, ssr_out, spc_out, sgr_out;
    logic [11:0] expevt_out, intevt_out;
    logic        entered, dslot_clear, wake;

    int checks = 0;
    int errors = 0;

    logic [31:0] e_pc = '0, e_sr = '0, e_ssr = '0, e_spc = '0, e_sgr = '0;
    logic [11:0] e_exp = '0, e_int = '0;
    logic        e_ent = 1'b0, e_dclr = 1'b0, e_wake = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst(rst), .take(take), .exc_pending(exc_pending),
        .exc_code(exc_code), .irq_req(irq_req), .irq_vector(irq_vector),
        .irq_level(irq_level), .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in),
        .vbr_in(vbr_in), .dslot_uncond(dslot_uncond), .dslot_cond(dslot_cond),
        .sleep_in(sleep_in), .pc_out(pc_out), .sr_out(sr_out), .ssr_out(ssr_out),
        .spc_out(spc_out), .sgr_out(sgr_out), .expevt_out(expevt_out),
        .intevt_out(intevt_out), .entered(entered), .dslot_clear(dslot_clear),
        .wake(wake)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic reset_class(input logic [11:0] c);
        return c == 12'h000 || c == 12'h020 || c == 12'h140;
    endfunction

    // Expected state from the requirements, using the inputs of this edge
    task automatic model();
        logic        bl;
        logic [11:0] code;
        logic        ex, iq;
        bl   = sr_in[28];
        code = (bl && exc_code != 12'h1E0) ? 12'h000 : exc_code;
        ex   = take && exc_pending;
        iq   = take && !exc_pending && irq_req && (!bl || sleep_in)
               && (irq_level > sr_in[7:4]);
        e_ent  = ex || iq;
        e_dclr = (ex || iq) && (dslot_uncond || dslot_cond);
        e_wake = (ex || iq) && sleep_in;
        if (ex || iq) begin
            e_ssr = sr_in;
            e_sgr = r15_in;
            e_sr  = sr_in | 32'h7000_0000;
            e_spc = (dslot_uncond || dslot_cond) ? pc_in - 32'd2 : pc_in;
            if (iq) begin
                e_pc  = vbr_in + 32'h600;
                e_int = irq_vector;
            end else begin
                e_exp = code;
                if (reset_class(code)) begin
                    e_pc = 32'hA000_0000;
                    e_sr[15] = 1'b0;
                    e_sr[7:4] = 4'hF;
                end else if (code == 12'h040 || code == 12'h060) begin
                    e_pc = vbr_in + 32'h400;
                end else begin
                    e_pc = vbr_in + 32'h100;
                    if (code == 12'h160) e_spc = e_spc + 32'd2;
                end
            end
        end
    endtask

    task automatic step(input string req);
        @(posedge clk);
        model();
        #1;
        chk(req, "pc_out", pc_out, e_pc);
        chk(req, "sr_out", sr_out, e_sr);
        chk(req, "ssr_out", ssr_out, e_ssr);
        chk(req, "spc_out", spc_out, e_spc);
        chk(req, "sgr_out", sgr_out, e_sgr);
        chk(req, "expevt_out", {20'd0, expevt_out}, {20'd0, e_exp});
        chk(req, "intevt_out", {20'd0, intevt_out}, {20'd0, e_int});
        chk(req, "entered", {31'd0, entered}, {31'd0, e_ent});
        chk(req, "dslot_clear", {31'd0, dslot_clear}, {31'd0, e_dclr});
        chk(req, "wake", {31'd0, wake}, {31'd0, e_wake});
        @(negedge clk);
    endtask

    task automatic setup(input logic t, input logic ep, input logic [11:0] ec,
                         input logic ir, input logic [3:0] lvl,
                         input logic [31:0] sr, input logic ds, input logic sl);
        take = t; exc_pending = ep; exc_code = ec; irq_req = ir;
        irq_level = lvl; sr_in = sr; dslot_uncond = ds; dslot_cond = 1'b0;
        sleep_in = sl;
        pc_in = 32'h0C00_1000; r15_in = 32'h0DEA_D000; vbr_in = 32'h8C00_0000;
        irq_vector = 12'h320;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk("R11", "pc_out", pc_out, 32'h0);
        chk("R11", "sr_out", sr_out, 32'h0);
        chk("R11", "entered", {31'd0, entered}, 32'h0);
        chk("R11", "expevt_out", {20'd0, expevt_out}, 32'h0);

        // R1: exception beats a simultaneous interrupt
        setup(1, 1, 12'h180, 1, 4'hF, 32'h0000_0000, 0, 0); step("R1");
        // R9: interrupt entry, level above mask
        setup(1, 0, 12'h180, 1, 4'h9, 32'h0000_0080, 0, 0); step("R9");
        // R3: level equal to mask is refused
        setup(1, 0, 12'h0, 1, 4'h8, 32'h0000_0080, 0, 0); step("R3");
        // R3: block bit refuses interrupt when awake
        setup(1, 0, 12'h0, 1, 4'hF, 32'h1000_0000, 0, 0); step("R3");
        // R3 / R10: block bit with sleep accepts interrupt and wakes
        setup(1, 0, 12'h0, 1, 4'hF, 32'h1000_0000, 0, 1); step("R10");
        // R2: escalation under block bit
        setup(1, 1, 12'h0A0, 0, 4'h0, 32'h1000_8000, 0, 0); step("R2");
        // R2: bypass code survives the block bit
        setup(1, 1, 12'h1E0, 0, 4'h0, 32'h1000_0000, 0, 0); step("R2");
        // R6: manual reset class clears FD, sets mask
        setup(1, 1, 12'h020, 0, 4'h0, 32'h0000_8030, 0, 0); step("R6");
        // R7: write miss goes to miss vector
        setup(1, 1, 12'h060, 0, 4'h0, 32'h0000_0000, 0, 0); step("R7");
        // R5: delay slot rewind
        setup(1, 1, 12'h180, 0, 4'h0, 32'h0000_0000, 1, 0); step("R5");
        // R8: trap advance, then trap in delay slot
        setup(1, 1, 12'h160, 0, 4'h0, 32'h0000_0000, 0, 0); step("R8");
        setup(1, 1, 12'h160, 0, 4'h0, 32'h0000_0000, 1, 0); step("R8");
        // R4: saved copies on a general exception
        setup(1, 1, 12'h100, 0, 4'h0, 32'h4000_00F3, 0, 0); step("R4");
        // R10: no strobe, nothing changes
        setup(0, 1, 12'h040, 1, 4'hF, 32'h0000_0000, 0, 0); step("R10");

        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic [11:0] pick [10];
            pick = '{12'h000, 12'h020, 12'h140, 12'h040, 12'h060,
                     12'h160, 12'h1E0, 12'h0A0, 12'h100, 12'h180};
            take         = ($urandom % 4) != 0;
            exc_pending  = ($urandom % 3) == 0;
            exc_code     = pick[$urandom % 10];
            irq_req      = $urandom % 2;
            irq_vector   = 12'($urandom);
            irq_level    = 4'($urandom);
            sr_in        = $urandom;
            pc_in        = $urandom & 32'hFFFF_FFFE;
            r15_in       = $urandom;
            vbr_in       = $urandom & 32'hFFFF_F000;
            dslot_uncond = ($urandom % 5) == 0;
            dslot_cond   = ($urandom % 5) == 0;
            sleep_in     = ($urandom % 4) == 0;
            step("RND");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule